// File: doc/BRIEF.md
# Banked Address Map Decoder

This block sits between an 8-bit-style CPU with a 16-bit address bus and the memories and peripherals of a banked system. Each cycle it looks at the CPU address, the read/write flag and the configuration bits held by a separate memory-management register file. From these it produces a target code and a physical offset, and the memory arrays and chip selects of the system act on that code and offset. The decoder is purely combinational and holds no state.

RAM is 2^(16+BANK_W) bytes, made up of banks of 64 KB. Every RAM access normally lands in the bank given by the bank select input. A bottom window and a top window of programmable size can force accesses back to the common bank 0, so that code and data stay visible whatever bank is selected. The two lowest 256-byte pages (page zero and page one) are remapped to any page of any bank.

Read accesses to enabled ROM ranges return ROM, but writes to those ranges always go to the RAM underneath. The 0xD000 to 0xDFFF area decodes to peripheral selects when I/O is enabled. When I/O is off, it holds character ROM for reads or falls back to plain RAM.

Top module: `amap_decode`

## Requirements
- R1: Addresses 0x0000 to 0x00FF select RAM (target 0) at physical offset {zp_bank, zp_page, addr[7:0]}, for reads and writes, whatever the enables and shared windows are.
- R2: Addresses 0x0100 to 0x01FF select RAM (target 0) at physical offset {sp_bank, sp_page, addr[7:0]}, whatever the enables and shared windows are.
- R3: The share size code gives the window size: 0 is 1 KB, 1 is 4 KB, 2 is 8 KB, 3 is 16 KB. With share_lo set, a RAM access at or above 0x0200 and below the size goes to bank 0. Any other RAM access that no window claims goes to {bank_sel, addr}.
- R4: With share_hi set, a RAM access at an address of 0x10000 minus the size or above goes to bank 0.
- R5: Reads of 0x4000 to 0x7FFF with bas_lo_en set give target 1, and reads of 0x8000 to 0xBFFF with bas_hi_en set give target 2. The offset in both cases is addr minus 0x4000.
- R6: Reads of 0xC000 to 0xCFFF with edit_en set give target 3 at offset addr minus 0x4000.
- R7: Reads of 0xE000 to 0xFFFF with kern_en set give target 4 at offset addr[12:0]. Address 0xFF00 is the exception (see R13).
- R8: A write never selects a ROM target (1 to 5). A write that lands in a ROM range goes to RAM under the bank and window rules.
- R9: With io_en set, 0xD000 to 0xDFFF decodes by address bits [11:8] as follows:
  - pages 0 to 3: target 6, offset addr[9:0]
  - page 4: target 7
  - page 5: target 8
  - page 6: target 9
  - pages 8 to 11: target 10, offset addr[9:0]
  - page C: target 11
  - page D: target 12
  - page E: target 13
  - page F: target 14
  
  Pages 4 to 6 and C to F use offset addr[7:0].
- R10: With io_en set, reads and writes of page 0xD7xx give the open-bus target 15 at offset 0. A read therefore returns 0xFF and a write is dropped.
- R11: With io_en clear and chr_en set, reads of 0xD000 to 0xDFFF give target 5 at offset addr[11:0]. Writes go to RAM.
- R12: With io_en and chr_en both clear, 0xD000 to 0xDFFF is RAM under the bank and window rules.
- R13: Any access to 0xFF00 gives target 8 at offset 0. Writes to 0xFF01 to 0xFF04 give target 8 at offset addr[7:0] and never reach RAM. Reads of 0xFF01 to 0xFF04 follow R7 or RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| io_en | input | 1 | Peripheral area enabled at 0xD000-0xDFFF |
| chr_en | input | 1 | Character ROM readable at 0xD000-0xDFFF when I/O is off |
| bas_lo_en | input | 1 | Low BASIC ROM readable at 0x4000-0x7FFF |
| bas_hi_en | input | 1 | High BASIC ROM readable at 0x8000-0xBFFF |
| edit_en | input | 1 | Editor ROM readable at 0xC000-0xCFFF |
| kern_en | input | 1 | Kernel ROM readable at 0xE000-0xFFFF |
| bank_sel | input | BANK_W | Selected RAM bank |
| share_lo | input | 1 | Bottom shared window enabled |
| share_hi | input | 1 | Top shared window enabled |
| share_code | input | 2 | Shared window size code |
| zp_page | input | 8 | Physical page for page zero |
| zp_bank | input | BANK_W | Physical bank for page zero |
| sp_page | input | 8 | Physical page for page one |
| sp_bank | input | BANK_W | Physical bank for page one |
| tgt_sel | output | 4 | Target code (0 RAM ... 15 open bus) |
| tgt_off | output | 16+BANK_W | RAM physical address, or offset in ROM or peripheral |

## Verification
The main function is tried with every combination of the six enables, both window enables, all four size codes and both banks, at forty addresses, once as a read and once as a write. The addresses are chosen to sit on every region edge and window edge: 0x03FF/0x0400, 0x0FFF/0x1000, 0x3FFF/0x4000, 0xBFFF/0xC000 and 0xFBFF/0xFC00. This tells an off-by-one in a window limit apart from a wrong size code. The page-relocation inputs change with the control word, so a page-zero access that wrongly follows the bank select or a shared window is exposed. The read/write pairing separates the ROM-read paths from write fall-through and the MMU write trap. The directed vectors pin down named corner cases: I/O off with and without character ROM, the empty peripheral page, and the MMU page boundaries.

// File: rtl/amap_pkg.sv
package amap_pkg;

  localparam int ADDR_W = 16;
  localparam int TGT_W  = 4;

  typedef enum logic [TGT_W-1:0] {
    T_RAM   = 4'd0,
    T_BAS_LO = 4'd1,
    T_BAS_HI = 4'd2,
    T_EDIT  = 4'd3,
    T_KERN  = 4'd4,
    T_CHAR  = 4'd5,
    T_VID   = 4'd6,
    T_SND   = 4'd7,
    T_MMU   = 4'd8,
    T_VDC   = 4'd9,
    T_COLR  = 4'd10,
    T_TMR_A = 4'd11,
    T_TMR_B = 4'd12,
    T_EXP_A = 4'd13,
    T_EXP_B = 4'd14,
    T_OPEN  = 4'd15
  } tgt_e;

  typedef enum logic [3:0] {
    Z_PAGE0, Z_PAGE1, Z_LOW, Z_BAS_LO, Z_BAS_HI,
    Z_EDIT, Z_IO, Z_HIGH, Z_FFPAGE
  } zone_e;

  // Size in bytes of a shared RAM window for a given size code.
  function automatic logic [ADDR_W-1:0] share_bytes(input logic [1:0] code);
    if (code == 2'd0) return 16'h0400;
    return 16'h0800 << code;
  endfunction

  // Lowest address covered by the top shared window.
  function automatic logic [ADDR_W-1:0] top_floor(input logic [1:0] code);
    return ~share_bytes(code) + 16'd1;
  endfunction

  function automatic logic [ADDR_W-1:0] basic_off(input logic [ADDR_W-1:0] a);
    return a - 16'h4000;
  endfunction

  function automatic logic [ADDR_W-1:0] kern_off(input logic [ADDR_W-1:0] a);
    return {3'b000, a[12:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] char_off(input logic [ADDR_W-1:0] a);
    return {4'h0, a[11:0]};
  endfunction

  // Peripheral select for one page of the I/O area.
  function automatic tgt_e io_tgt_of(input logic [3:0] pg);
    case (pg)
      4'h0, 4'h1, 4'h2, 4'h3: return T_VID;
      4'h4:                   return T_SND;
      4'h5:                   return T_MMU;
      4'h6:                   return T_VDC;
      4'h8, 4'h9, 4'hA, 4'hB: return T_COLR;
      4'hC:                   return T_TMR_A;
      4'hD:                   return T_TMR_B;
      4'hE:                   return T_EXP_A;
      4'hF:                   return T_EXP_B;
      default:                return T_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/amap_zone.sv
module amap_zone
  import amap_pkg::*;
(
  input  logic [7:0] addr_page,
  output zone_e      zone
);
  always_comb begin
    if (addr_page == 8'h00)      zone = Z_PAGE0;
    else if (addr_page == 8'h01) zone = Z_PAGE1;
    else if (addr_page < 8'h40)  zone = Z_LOW;
    else if (addr_page < 8'h80)  zone = Z_BAS_LO;
    else if (addr_page < 8'hC0)  zone = Z_BAS_HI;
    else if (addr_page < 8'hD0)  zone = Z_EDIT;
    else if (addr_page < 8'hE0)  zone = Z_IO;
    else if (addr_page < 8'hFF)  zone = Z_HIGH;
    else                         zone = Z_FFPAGE;
  end
endmodule

// File: rtl/amap_ram_route.sv
module amap_ram_route
  import amap_pkg::*;
#(
  parameter int BANK_W = 1,
  localparam int PHYS_W = ADDR_W + BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              share_lo,
  input  logic              share_hi,
  input  logic [1:0]        share_code,
  input  logic [7:0]        zp_page,
  input  logic [BANK_W-1:0] zp_bank,
  input  logic [7:0]        sp_page,
  input  logic [BANK_W-1:0] sp_bank,
  output logic [PHYS_W-1:0] ram_addr,
  output logic              lo_hit,
  output logic              hi_hit
);
  logic              is_pg0, is_pg1;
  logic [BANK_W-1:0] eff_bank;

  always_comb begin
    is_pg0   = (addr[15:8] == 8'h00);
    is_pg1   = (addr[15:8] == 8'h01);
    lo_hit   = share_lo && !is_pg0 && !is_pg1 && (addr < share_bytes(share_code));
    hi_hit   = share_hi && (addr >= top_floor(share_code));
    eff_bank = (lo_hit || hi_hit) ? '0 : bank_sel;
    if (is_pg0)      ram_addr = {zp_bank, zp_page, addr[7:0]};
    else if (is_pg1) ram_addr = {sp_bank, sp_page, addr[7:0]};
    else             ram_addr = {eff_bank, addr};
  end

  // R3: the bottom window never reaches 0x4000 and the top never below 0xC000
  always_comb begin
    p_win_disjoint_r3: assert (!(lo_hit && hi_hit))
      else $error("shared windows overlap at %h", addr);
  end

  // R4: an access claimed by a shared window lands in bank 0
  always_comb begin
    if ((lo_hit || hi_hit) && !is_pg0 && !is_pg1)
      p_shared_bank0_r4: assert (ram_addr[PHYS_W-1 -: BANK_W] == '0)
        else $error("shared access left bank 0 at %h", addr);
  end
endmodule

// File: rtl/amap_io_page.sv
module amap_io_page
  import amap_pkg::*;
(
  input  logic [3:0]        page,
  input  logic [9:0]        addr_lo,
  output tgt_e              io_tgt,
  output logic [ADDR_W-1:0] io_off
);
  localparam int NPAGE = 16;

  tgt_e page_tgt  [NPAGE];
  logic page_wide [NPAGE];

  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    assign page_tgt[g]  = io_tgt_of(4'(g));
    assign page_wide[g] = (io_tgt_of(4'(g)) == T_VID) || (io_tgt_of(4'(g)) == T_COLR);
  end

  always_comb begin
    io_tgt = page_tgt[page];
    if (io_tgt == T_OPEN)     io_off = '0;
    else if (page_wide[page]) io_off = {6'b0, addr_lo};
    else                      io_off = {8'b0, addr_lo[7:0]};
  end

  // R10: only the unpopulated page gives the open-bus return
  always_comb begin
    p_open_page_r10: assert ((io_tgt == T_OPEN) == (page == 4'h7))
      else $error("open-bus decode on page %h", page);
  end
endmodule

// File: rtl/amap_decode.sv
module amap_decode
  import amap_pkg::*;
#(
  parameter int BANK_W = 1,
  localparam int PHYS_W = ADDR_W + BANK_W
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              io_en,
  input  logic              chr_en,
  input  logic              bas_lo_en,
  input  logic              bas_hi_en,
  input  logic              edit_en,
  input  logic              kern_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              share_lo,
  input  logic              share_hi,
  input  logic [1:0]        share_code,
  input  logic [7:0]        zp_page,
  input  logic [BANK_W-1:0] zp_bank,
  input  logic [7:0]        sp_page,
  input  logic [BANK_W-1:0] sp_bank,
  output logic [TGT_W-1:0]  tgt_sel,
  output logic [PHYS_W-1:0] tgt_off
);
  zone_e             zone;
  logic [PHYS_W-1:0] ram_addr;
  logic              lo_hit, hi_hit;
  tgt_e              io_tgt;
  logic [ADDR_W-1:0] io_off;
  tgt_e              tgt;
  logic              mmu_cfg_hit;
  logic              mmu_wr_trap;

  amap_zone u_zone (
    .addr_page (cpu_addr[15:8]),
    .zone      (zone)
  );

  amap_ram_route #(.BANK_W(BANK_W)) u_route (
    .addr       (cpu_addr),
    .bank_sel   (bank_sel),
    .share_lo   (share_lo),
    .share_hi   (share_hi),
    .share_code (share_code),
    .zp_page    (zp_page),
    .zp_bank    (zp_bank),
    .sp_page    (sp_page),
    .sp_bank    (sp_bank),
    .ram_addr   (ram_addr),
    .lo_hit     (lo_hit),
    .hi_hit     (hi_hit)
  );

  amap_io_page u_io (
    .page    (cpu_addr[11:8]),
    .addr_lo (cpu_addr[9:0]),
    .io_tgt  (io_tgt),
    .io_off  (io_off)
  );

  // MMU events on the top page, named for the checks below (R13)
  assign mmu_cfg_hit = (zone == Z_FFPAGE) && (cpu_addr[7:0] == 8'h00);
  assign mmu_wr_trap = (zone == Z_FFPAGE) && cpu_wr &&
                       (cpu_addr[7:0] != 8'h00) && (cpu_addr[7:0] <= 8'h04);

  always_comb begin
    tgt     = T_RAM;
    tgt_off = ram_addr;
    case (zone)
      Z_BAS_LO: if (!cpu_wr && bas_lo_en) begin
        tgt = T_BAS_LO; tgt_off = PHYS_W'(basic_off(cpu_addr));
      end
      Z_BAS_HI: if (!cpu_wr && bas_hi_en) begin
        tgt = T_BAS_HI; tgt_off = PHYS_W'(basic_off(cpu_addr));
      end
      Z_EDIT: if (!cpu_wr && edit_en) begin
        tgt = T_EDIT; tgt_off = PHYS_W'(basic_off(cpu_addr));
      end
      Z_IO: begin
        if (io_en) begin
          tgt = io_tgt; tgt_off = PHYS_W'(io_off);
        end else if (chr_en && !cpu_wr) begin
          tgt = T_CHAR; tgt_off = PHYS_W'(char_off(cpu_addr));
        end
      end
      Z_HIGH: if (!cpu_wr && kern_en) begin
        tgt = T_KERN; tgt_off = PHYS_W'(kern_off(cpu_addr));
      end
      Z_FFPAGE: begin
        if (mmu_cfg_hit || mmu_wr_trap) begin
          tgt = T_MMU; tgt_off = PHYS_W'(cpu_addr[7:0]);
        end else if (!cpu_wr && kern_en) begin
          tgt = T_KERN; tgt_off = PHYS_W'(kern_off(cpu_addr));
        end
      end
      default: ;
    endcase
  end

  assign tgt_sel = tgt;

  // R8 (with R5, R6, R7, R11): writes never pick a ROM target
  always_comb begin
    if (cpu_wr)
      p_wr_no_rom_r8: assert (tgt_sel == 4'd0 || tgt_sel > 4'd5)
        else $error("write decoded to ROM target %0d at %h", tgt_sel, cpu_addr);
  end

  // R11: with I/O off, the only peripheral target left is the MMU on the top page
  always_comb begin
    if (!io_en && tgt_sel >= 4'd6)
      p_io_gate_r11: assert (tgt_sel == 4'd8 && cpu_addr >= 16'hFF00)
        else $error("peripheral %0d selected with I/O off at %h", tgt_sel, cpu_addr);
  end

  // R13: writes to 0xFF01..0xFF04 are caught as MMU accesses and keep off RAM
  always_comb begin
    if (cpu_wr && cpu_addr >= 16'hFF01 && cpu_addr <= 16'hFF04)
      p_mmu_trap_r13: assert (tgt_sel == 4'd8)
        else $error("MMU write at %h escaped to target %0d", cpu_addr, tgt_sel);
  end

  // R1/R2: the two low pages are RAM no matter what else is configured
  always_comb begin
    if (cpu_addr < 16'h0200)
      p_low_pages_ram_r1: assert (tgt_sel == 4'd0 && !lo_hit && !hi_hit)
        else $error("low page %h not routed to relocated RAM", cpu_addr);
  end
endmodule

// File: tb/sim_amap_decode.sv
module sim_amap_decode;

  localparam int BANK_W = 1;
  localparam int PHYS_W = 16 + BANK_W;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0]       cpu_addr = '0;
  logic              cpu_wr = 1'b0;
  logic [10:0]       ctl = '0;
  logic [7:0]        zp_page = '0, sp_page = '0;
  logic [BANK_W-1:0] zp_bank = '0, sp_bank = '0;
  logic [3:0]        tgt_sel;
  logic [PHYS_W-1:0] tgt_off;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // ctl layout: [10] bank, [9] share_hi, [8] share_lo, [7:6] size code,
  // [5] kern, [4] edit, [3] bas_hi, [2] bas_lo, [1] chr, [0] io
  amap_decode #(.BANK_W(BANK_W)) u0 (
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .io_en      (ctl[0]),
    .chr_en     (ctl[1]),
    .bas_lo_en  (ctl[2]),
    .bas_hi_en  (ctl[3]),
    .edit_en    (ctl[4]),
    .kern_en    (ctl[5]),
    .bank_sel   (ctl[10]),
    .share_lo   (ctl[8]),
    .share_hi   (ctl[9]),
    .share_code (ctl[7:6]),
    .zp_page    (zp_page),
    .zp_bank    (zp_bank),
    .sp_page    (sp_page),
    .sp_bank    (sp_bank),
    .tgt_sel    (tgt_sel),
    .tgt_off    (tgt_off)
  );

  typedef struct packed {
    logic [15:0] a;
    logic        w;
    logic [10:0] c;
    logic [3:0]  t;
    logic [16:0] o;
  } vec_t;

  // zp = page 0x37 bank 1, sp = page 0x8A bank 0 for every row
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{16'h0012, 1'b0, 11'h43D, 4'd0,  17'h13712}, // R1
    '{16'h01FE, 1'b1, 11'h43D, 4'd0,  17'h08AFE}, // R2
    '{16'h4123, 1'b0, 11'h43D, 4'd1,  17'h00123}, // R5
    '{16'hBFFF, 1'b0, 11'h43D, 4'd2,  17'h07FFF}, // R5
    '{16'h8000, 1'b1, 11'h43D, 4'd0,  17'h18000}, // R8
    '{16'hC456, 1'b0, 11'h43D, 4'd3,  17'h08456}, // R6
    '{16'hFFFE, 1'b0, 11'h43D, 4'd4,  17'h01FFE}, // R7
    '{16'hD020, 1'b0, 11'h43D, 4'd6,  17'h00020}, // R9
    '{16'hDB05, 1'b1, 11'h43D, 4'd10, 17'h00305}, // R9
    '{16'hD7AA, 1'b0, 11'h43D, 4'd15, 17'h00000}, // R10
    '{16'hD755, 1'b1, 11'h43D, 4'd15, 17'h00000}, // R10
    '{16'hFF00, 1'b1, 11'h43D, 4'd8,  17'h00000}, // R13
    '{16'hFF03, 1'b1, 11'h43D, 4'd8,  17'h00003}, // R13
    '{16'hFF03, 1'b0, 11'h43D, 4'd4,  17'h01F03}, // R13
    '{16'hD123, 1'b0, 11'h43E, 4'd5,  17'h00123}, // R11
    '{16'hD123, 1'b1, 11'h43E, 4'd0,  17'h1D123}, // R11
    '{16'hD400, 1'b0, 11'h6FC, 4'd0,  17'h0D400}, // R12
    '{16'h0FFF, 1'b0, 11'h540, 4'd0,  17'h00FFF}, // R3
    '{16'h1000, 1'b0, 11'h540, 4'd0,  17'h11000}, // R3
    '{16'hE000, 1'b1, 11'h6BD, 4'd0,  17'h0E000}, // R4
    '{16'hDFFF, 1'b1, 11'h6BD, 4'd14, 17'h000FF}, // R9
    '{16'hDFFF, 1'b1, 11'h6BC, 4'd0,  17'h1DFFF}, // R4
    '{16'h03FF, 1'b0, 11'h500, 4'd0,  17'h003FF}, // R3
    '{16'h0400, 1'b0, 11'h500, 4'd0,  17'h10400}  // R3
  };

  localparam int NA = 40;
  localparam logic [15:0] ADDRS [NA] = '{
    16'h0000, 16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h03FF, 16'h0400, 16'h0FFF,
    16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hBFFF,
    16'hC000, 16'hCFFF, 16'hD000, 16'hD3FF, 16'hD4FF, 16'hD500, 16'hD6C1, 16'hD700,
    16'hD9AB, 16'hDC01, 16'hDD02, 16'hDE03, 16'hDF04, 16'hE000, 16'hEFFF, 16'hF000,
    16'hFBFF, 16'hFC00, 16'hFEFF, 16'hFF00, 16'hFF01, 16'hFF04, 16'hFF05, 16'hFFFF
  };

  // Independent model of the address map, written from the requirements.
  function automatic void ref_map(input int a, input bit w, input logic [10:0] c,
                                  input int zpg, input int zb, input int spg, input int sb,
                                  output int t, output int o, output string tag);
    int size, rb, pg;
    case (c[7:6])
      2'd0: size = 1024;
      2'd1: size = 4096;
      2'd2: size = 8192;
      default: size = 16384;
    endcase
    rb = int'(c[10]);
    if (c[8] && a < size) rb = 0;
    if (c[9] && a + size > 65535) rb = 0;
    t = 0; o = rb * 65536 + a;
    if (a < 256) begin
      o = zb * 65536 + zpg * 256 + a; tag = "R1";
    end else if (a < 512) begin
      o = sb * 65536 + spg * 256 + (a - 256); tag = "R2";
    end else if (a >= 'h4000 && a < 'h8000 && !w && c[2]) begin
      t = 1; o = a - 'h4000; tag = "R5";
    end else if (a >= 'h8000 && a < 'hC000 && !w && c[3]) begin
      t = 2; o = a - 'h4000; tag = "R5";
    end else if (a >= 'hC000 && a < 'hD000 && !w && c[4]) begin
      t = 3; o = a - 'h4000; tag = "R6";
    end else if (a >= 'hD000 && a < 'hE000 && c[0]) begin
      pg = (a >> 8) & 15; tag = "R9";
      if (pg <= 3)       begin t = 6;  o = a & 'h3FF; end
      else if (pg == 4)  begin t = 7;  o = a & 'hFF; end
      else if (pg == 5)  begin t = 8;  o = a & 'hFF; end
      else if (pg == 6)  begin t = 9;  o = a & 'hFF; end
      else if (pg == 7)  begin t = 15; o = 0; tag = "R10"; end
      else if (pg <= 11) begin t = 10; o = a & 'h3FF; end
      else               begin t = pg - 1; o = a & 'hFF; end
    end else if (a >= 'hD000 && a < 'hE000 && c[1] && !w) begin
      t = 5; o = a - 'hD000; tag = "R11";
    end else if (a == 'hFF00) begin
      t = 8; o = 0; tag = "R13";
    end else if (w && a >= 'hFF01 && a <= 'hFF04) begin
      t = 8; o = a - 'hFF00; tag = "R13";
    end else if (a >= 'hE000 && !w && c[5]) begin
      t = 4; o = a - 'hE000; tag = "R7";
    end else if (w && a >= 'h4000) tag = "R8";
    else if (a >= 'hD000 && a < 'hE000) tag = "R12";
    else if (a >= 'hC000) tag = "R4";
    else tag = "R3";
  endfunction

  task automatic check(input string tag, input int exp_t, input int exp_o);
    checks++;
    if (int'(tgt_sel) != exp_t || int'(tgt_off) != exp_o) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d ctl=%h: got tgt=%0d off=%h, expected tgt=%0d off=%h",
               tag, cpu_addr, cpu_wr, ctl, tgt_sel, tgt_off, exp_t, exp_o);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int et, eo;
    string tg;

    // Idle state: all inputs zero decodes to RAM at physical 0 (R1)
    #5;
    check("R1 idle", 0, 0);

    // Vector table
    zp_page = 8'h37; zp_bank = 1'b1; sp_page = 8'h8A; sp_bank = 1'b0;
    for (int i = 0; i < NV; i++) begin
      cpu_addr = VEC[i].a; cpu_wr = VEC[i].w; ctl = VEC[i].c;
      #2;
      check($sformatf("table row %0d", i), int'(VEC[i].t), int'(VEC[i].o));
    end

    // Directed: page zero relocated to the last page of bank 1 (R1)
    ctl = 11'h7FF; zp_page = 8'hFF; zp_bank = 1'b1; cpu_addr = 16'h0080; cpu_wr = 1'b0;
    #2; check("R1 relocate", 0, 'h1FF80);
    // Directed: page one in bank 0 even with bank 1 selected and windows on (R2)
    sp_page = 8'h00; sp_bank = 1'b0; cpu_addr = 16'h0101; cpu_wr = 1'b1;
    #2; check("R2 relocate", 0, 'h00001);
    // Directed: top window at 16 KB boundary (R4)
    ctl = 11'h6C0; cpu_addr = 16'hBFFF; cpu_wr = 1'b1;
    #2; check("R4 below floor", 0, 'h1BFFF);
    cpu_addr = 16'hC000;
    #2; check("R4 at floor", 0, 'h0C000);

    // Full sweep of every control word against the model
    for (int c = 0; c < 2048; c++) begin
      for (int i = 0; i < NA; i++) begin
        for (int w = 0; w < 2; w++) begin
          ctl = 11'(c);
          zp_page = 8'(c) ^ 8'h5A; zp_bank = 1'(c >> 1);
          sp_page = 8'(c >> 2);    sp_bank = ~1'(c);
          cpu_addr = ADDRS[i]; cpu_wr = 1'(w);
          #1;
          ref_map(int'(ADDRS[i]), w[0], 11'(c), int'(zp_page), int'(zp_bank),
                  int'(sp_page), int'(sp_bank), et, eo, tg);
          check(tg, et, eo);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule